// File: doc/BRIEF.md
# Zero-Cross Synchronized Stereo Limiter

This block watches a stereo stream of signed two's-complement PCM samples, one left/right pair per sample strobe, and decides how much attenuation the two channels need. The samples it receives are the limiter's own output level, taken before saturation in a widened format with extra headroom bits. Whenever the louder of the two channels reaches a programmable detection level, a single attenuation code is raised. Both channels share this code, and each step is 0.375 dB. The number of steps added each time depends on how far the level overshoots. The code only ever rises. Recovery and the dB-to-linear gain multiply are done outside the block.

Each channel has its own copy of the code. A channel picks up a new code at its own zero crossing, or when a timeout expires. A new code can also take effect on the same sample it is issued. This happens when zero-cross gating is turned off, or when fast mode is on and the level is at or above full scale. The block also passes the samples on, clipped to the output width. It raises a flag while the level sits in the band just below the detection level, which the external recovery logic uses to restart its wait counter.

Top module: `zc_stereo_limiter`

## Requirements
- R1: On a strobed sample with `lim_en` high, the limiter triggers when the peak max(|left|,|right|) is at or above the detection level. The trigger raises `att_shared` by the step count of R3, unless R8 blocks it. `att_shared` never decreases.
- R2: The detection level is chosen by `det_sel` 0/1/2/3 (−2.5/−4.1/−6.0/−8.5 dBFS). With W=16 these are the magnitudes 24573/20439/16423/12316. Full scale (FS) is 2^(W−1) = 32768.
- R3: With zero-cross gating on, the step count comes from `step_sel` and the overshoot zone. The zones are: below FS; at or above FS; at or above FS+6 dB (65381); at or above FS+12 dB (130452). Counts per zone are: code 0 → 1/1/1/1, code 1 → 2/2/2/2, code 2 → 2/4/4/8, code 3 → 1/2/4/8.
- R4: With `zc_gate_en` low, every trigger adds exactly 1 step, whatever `step_sel` is. Both `att_left` and `att_right` take the new value on the same update as `att_shared`.
- R5: With `zc_gate_en` and `fast_en` both high and the peak at or above FS, the new code reaches both channels at once. This applies even if an earlier channel update is still pending, and it cancels that pending update.
- R6: In any other case, a trigger marks both channels pending. A pending channel copies `att_shared` at the first later sample that is a zero crossing of that channel. A zero crossing is a sign-bit change from the channel's previous sample, or a sample equal to zero; the previous sample is 0 after reset. This holds whatever the level when `fast_en` is low.
- R7: `tmo_sel` 0/1/2/3 sets the timeout to 128/256/512/1024 samples. A channel still pending on the Nth strobed sample after the trigger sample takes the code on that sample.
- R8: While either channel is pending, triggers that would not be applied at once are ignored.
- R9: With `lim_en` low, `att_shared` does not change. Pending channel updates still complete.
- R10: `rcv_band` is high after a sample whose peak is below the detection level but at or above the band floor. The floor is 20439/16423/12316/8231 for `det_sel` 0/1/2/3.
- R11: `out_left`/`out_right` are the input samples clipped to the W-bit range. `out_valid` is `in_valid` delayed by one cycle. Every output updates one clock after a strobe and holds between strobes.
- R12: `att_shared` saturates at its all-ones code (255 for AW=8).
- R13: Synchronous active-low reset clears all outputs, all pending flags and the timeout counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_left | input | W+HR | Left sample, two's complement, pre-saturation |
| in_right | input | W+HR | Right sample, two's complement, pre-saturation |
| lim_en | input | 1 | Limiter enable |
| det_sel | input | 2 | Detection level select |
| step_sel | input | 2 | Step-count mode select |
| tmo_sel | input | 2 | Zero-crossing timeout select |
| zc_gate_en | input | 1 | Zero-cross gating enable |
| fast_en | input | 1 | Immediate update above full scale |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | W | Clipped left sample |
| out_right | output | W | Clipped right sample |
| att_shared | output | AW | Shared attenuation code, 0.375 dB per step |
| att_left | output | AW | Attenuation code in use on the left channel |
| att_right | output | AW | Attenuation code in use on the right channel |
| rcv_band | output | 1 | Peak of last sample in the recovery-counter reset band |

## Verification
A wrong step count or overshoot zone shows up on `att_shared` one clock after the triggering strobe. A pending flag or zero-crossing history that goes wrong shows up on `att_left`/`att_right`: the channel takes the code on the wrong sample, or does not take it. A corrupt timeout counter only becomes visible when the timeout is reached, which can be up to 1024 samples after the trigger. It then shows as a channel code updating early or late. A bad threshold constant only shows when a sample lands between the true and wrong levels, so the boundaries are driven one count apart.

// File: rtl/zcl_pkg.sv
// Shared constants and helpers for the zero-cross stereo limiter.
// Assumes level ratios are given in Q15 relative to a full scale of 32768,
// scaled to the configured sample width at elaboration time.
package zcl_pkg;

    typedef enum logic [1:0] {
        ZONE_THR  = 2'd0,
        ZONE_FS   = 2'd1,
        ZONE_FS6  = 2'd2,
        ZONE_FS12 = 2'd3
    } zone_e;

    localparam logic [17:0] RATIO_FS   = 18'd32768;
    localparam logic [17:0] RATIO_FS6  = 18'd65381;
    localparam logic [17:0] RATIO_FS12 = 18'd130452;

    // Detection level ratio for each select code
    function automatic logic [17:0] det_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 18'd24573;
            2'd1:    return 18'd20439;
            2'd2:    return 18'd16423;
            default: return 18'd12316;
        endcase
    endfunction

    // Recovery-band floor ratio for each select code
    function automatic logic [17:0] band_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 18'd20439;
            2'd1:    return 18'd16423;
            2'd2:    return 18'd12316;
            default: return 18'd8231;
        endcase
    endfunction

    // Scale a Q15 ratio to a magnitude for a full scale of 2^fs_exp
    function automatic logic [31:0] lvl_of(input logic [17:0] ratio, input int fs_exp);
        logic [63:0] t;
        t = (64'(ratio) << fs_exp) >> 15;
        return t[31:0];
    endfunction

    // Steps to add for a step mode and an overshoot zone
    function automatic logic [3:0] step_count(input logic [1:0] mode, input zone_e zone);
        case (mode)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return (zone == ZONE_THR) ? 4'd2 : ((zone == ZONE_FS12) ? 4'd8 : 4'd4);
            default: return 4'(1 << zone);
        endcase
    endfunction

endpackage

// File: rtl/zcl_level_detect.sv
// Level classification for one stereo sample pair.
// Takes the peak magnitude of both channels and compares it against the
// detection level, the recovery-band floor and the full-scale overshoot
// bands. Purely combinational; assumes W+HR <= 31.
module zcl_level_detect #(
    parameter int W  = 16,
    parameter int HR = 3
) (
    input  logic [W+HR-1:0] smp_l,
    input  logic [W+HR-1:0] smp_r,
    input  logic [1:0]      det_sel,
    output logic            over_thr,
    output logic            over_fs,
    output zcl_pkg::zone_e  zone,
    output logic            in_band
);
    import zcl_pkg::*;

    localparam int IW = W + HR;

    logic [31:0] det_tab  [4];
    logic [31:0] band_tab [4];
    localparam logic [31:0] LV_FS   = lvl_of(RATIO_FS,   W - 1);
    localparam logic [31:0] LV_FS6  = lvl_of(RATIO_FS6,  W - 1);
    localparam logic [31:0] LV_FS12 = lvl_of(RATIO_FS12, W - 1);

    // Build the per-code level tables
    for (genvar g = 0; g < 4; g++) begin : g_lvl
        assign det_tab[g]  = lvl_of(det_ratio(2'(g)),  W - 1);
        assign band_tab[g] = lvl_of(band_ratio(2'(g)), W - 1);
    end

    logic [IW-1:0] mag_l, mag_r, peak;
    logic [31:0]   pk;

    // Magnitudes and peak of the pair
    always_comb begin
        mag_l = smp_l[IW-1] ? (~smp_l + 1'b1) : smp_l;
        mag_r = smp_r[IW-1] ? (~smp_r + 1'b1) : smp_r;
        peak  = (mag_l > mag_r) ? mag_l : mag_r;
        pk    = 32'(peak);
    end

    // Zone and threshold decisions
    always_comb begin
        over_thr = pk >= det_tab[det_sel];
        in_band  = (pk < det_tab[det_sel]) && (pk >= band_tab[det_sel]);
        over_fs  = pk >= LV_FS;
        if (pk >= LV_FS12)     zone = ZONE_FS12;
        else if (pk >= LV_FS6) zone = ZONE_FS6;
        else if (over_fs)      zone = ZONE_FS;
        else                   zone = ZONE_THR;
    end

endmodule

// File: rtl/zcl_atten_ctrl.sv
// Shared attenuation code, step selection, trigger decision and the
// zero-crossing timeout counter. Assumes the channel units apply load_now
// and pend_set with priority over their own timeout and zero-cross logic.
module zcl_atten_ctrl #(
    parameter int AW      = 8,
    parameter int TMO_MIN = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic           enable,
    input  logic           over_thr,
    input  logic           over_fs,
    input  zcl_pkg::zone_e zone,
    input  logic [1:0]     step_sel,
    input  logic [1:0]     tmo_sel,
    input  logic           zc_en,
    input  logic           fast_en,
    input  logic           any_pending,
    output logic [AW-1:0]  att,
    output logic [AW-1:0]  new_att,
    output logic           load_now,
    output logic           pend_set,
    output logic           timeout
);
    import zcl_pkg::*;

    localparam int             TMO_MAX = TMO_MIN * 8;
    localparam int             CW      = $clog2(TMO_MAX) + 1;
    localparam logic [AW-1:0]  ATT_MAX = {AW{1'b1}};

    logic [CW-1:0] cnt, cnt_inc, tmo_lim;
    logic [AW:0]   sum;
    logic [3:0]    step;
    logic          imm, fire;

    // Step size, saturating sum and the trigger decision
    always_comb begin
        imm      = !zc_en || (fast_en && over_fs);
        step     = zc_en ? step_count(step_sel, zone) : 4'd1;
        sum      = {1'b0, att} + (AW+1)'(step);
        new_att  = (sum > (AW+1)'(ATT_MAX)) ? ATT_MAX : sum[AW-1:0];
        fire     = smp_valid && enable && over_thr && (imm || !any_pending);
        load_now = fire && imm;
        pend_set = fire && !imm;
        tmo_lim  = CW'(TMO_MIN) << tmo_sel;
        cnt_inc  = cnt + 1'b1;
        timeout  = smp_valid && any_pending && (cnt_inc >= tmo_lim);
    end

    // Shared code register and sample counter since the last issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att <= '0;
            cnt <= '0;
        end else if (fire) begin
            att <= new_att;
            cnt <= '0;
        end else if (smp_valid && any_pending) begin
            cnt <= cnt_inc;
        end
    end

    assert_att_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        att >= $past(att));
    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (att - $past(att)) <= AW'(8));
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && enable && over_thr && !zc_en) |=> ((att == ATT_MAX) || (att == $past(att) + 1'b1)));
    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (att == $past(att)));
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TMO_MAX));

endmodule

// File: rtl/zcl_chan.sv
// One channel's copy of the attenuation code. Tracks the previous sample
// for sign-change detection and holds a pending flag until the channel
// crosses zero or the shared timeout fires. Assumes load_now and pend_set
// are only raised on strobed samples.
module zcl_chan #(
    parameter int IW = 19,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [IW-1:0] sample,
    input  logic          load_now,
    input  logic          pend_set,
    input  logic [AW-1:0] load_val,
    input  logic [AW-1:0] shared_att,
    input  logic          timeout,
    output logic [AW-1:0] att_out,
    output logic          pending
);
    logic [IW-1:0] prev;
    logic          zc;

    // Zero crossing: exact zero or sign flip against the previous sample
    always_comb zc = (sample == '0) || (sample[IW-1] != prev[IW-1]);

    // Immediate load, pending set, or deferred pickup of the shared code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev    <= '0;
            att_out <= '0;
            pending <= 1'b0;
        end else if (smp_valid) begin
            prev <= sample;
            if (load_now) begin
                att_out <= load_val;
                pending <= 1'b0;
            end else if (pend_set) begin
                pending <= 1'b1;
            end else if (pending && (zc || timeout)) begin
                att_out <= shared_att;
                pending <= 1'b0;
            end
        end
    end

    assert_chan_le_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        att_out <= shared_att);
    assert_chan_strobe_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(att_out));
    assert_pend_holds_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !smp_valid) |=> pending);

endmodule

// File: rtl/zc_stereo_limiter.sv
// Top of the zero-cross synchronized stereo limiter. Classifies each
// stereo sample, drives the shared attenuation code and the two
// per-channel codes, clips the samples to W bits and flags the
// recovery-counter reset band. Inputs are two's complement with HR
// headroom bits above the W-bit output range.
module zc_stereo_limiter #(
    parameter int W       = 16,
    parameter int HR      = 3,
    parameter int AW      = 8,
    parameter int TMO_MIN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W+HR-1:0]   in_left,
    input  logic [W+HR-1:0]   in_right,
    input  logic              lim_en,
    input  logic [1:0]        det_sel,
    input  logic [1:0]        step_sel,
    input  logic [1:0]        tmo_sel,
    input  logic              zc_gate_en,
    input  logic              fast_en,
    output logic              out_valid,
    output logic [W-1:0]      out_left,
    output logic [W-1:0]      out_right,
    output logic [AW-1:0]     att_shared,
    output logic [AW-1:0]     att_left,
    output logic [AW-1:0]     att_right,
    output logic              rcv_band
);
    localparam int IW = W + HR;

    logic           over_thr, over_fs, in_band;
    zcl_pkg::zone_e zone;
    logic [AW-1:0]  new_att;
    logic           load_now, pend_set, timeout;
    logic [1:0]     pend;
    logic [IW-1:0]  smp   [2];
    logic [AW-1:0]  catt  [2];
    logic [W-1:0]   clip  [2];

    assign smp[0] = in_left;
    assign smp[1] = in_right;

    zcl_level_detect #(.W(W), .HR(HR)) i_level (
        .smp_l    (in_left),
        .smp_r    (in_right),
        .det_sel  (det_sel),
        .over_thr (over_thr),
        .over_fs  (over_fs),
        .zone     (zone),
        .in_band  (in_band)
    );

    zcl_atten_ctrl #(.AW(AW), .TMO_MIN(TMO_MIN)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (in_valid),
        .enable      (lim_en),
        .over_thr    (over_thr),
        .over_fs     (over_fs),
        .zone        (zone),
        .step_sel    (step_sel),
        .tmo_sel     (tmo_sel),
        .zc_en       (zc_gate_en),
        .fast_en     (fast_en),
        .any_pending (|pend),
        .att         (att_shared),
        .new_att     (new_att),
        .load_now    (load_now),
        .pend_set    (pend_set),
        .timeout     (timeout)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        zcl_chan #(.IW(IW), .AW(AW)) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_valid  (in_valid),
            .sample     (smp[c]),
            .load_now   (load_now),
            .pend_set   (pend_set),
            .load_val   (new_att),
            .shared_att (att_shared),
            .timeout    (timeout),
            .att_out    (catt[c]),
            .pending    (pend[c])
        );

        // Clip the widened sample to the W-bit range
        always_comb begin
            if (smp[c][IW-1:W-1] == {(HR+1){smp[c][IW-1]}})
                clip[c] = smp[c][W-1:0];
            else
                clip[c] = smp[c][IW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
    end

    assign att_left  = catt[0];
    assign att_right = catt[1];

    // Output sample, strobe and recovery-band flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            rcv_band  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= clip[0];
                out_right <= clip[1];
                rcv_band  <= in_band;
            end
        end
    end

    assert_band_no_trigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && rcv_band) |-> (att_shared == $past(att_shared)));
    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));
    assert_left_le_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (att_left <= att_shared) && (att_right <= att_shared));

endmodule

// File: tb/test_zc_stereo_limiter.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against every output on every falling edge.
module test_zc_stereo_limiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [18:0] in_left = '0, in_right = '0;
    logic        lim_en = 1'b0;
    logic [1:0]  det_sel = '0, step_sel = '0, tmo_sel = '0;
    logic        zc_gate_en = 1'b0, fast_en = 1'b0;
    logic        out_valid;
    logic [15:0] out_left, out_right;
    logic [7:0]  att_shared, att_left, att_right;
    logic        rcv_band;

    always #2.5 clk = ~clk;

    zc_stereo_limiter i_zc_stereo_limiter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .lim_en(lim_en),
        .det_sel(det_sel), .step_sel(step_sel), .tmo_sel(tmo_sel),
        .zc_gate_en(zc_gate_en), .fast_en(fast_en), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .att_shared(att_shared),
        .att_left(att_left), .att_right(att_right), .rcv_band(rcv_band)
    );

    int    n_chk = 0, n_fail = 0;
    string phase = "R13";
    bit    started = 0;

    // reference model state
    int m_att, m_al, m_ar, m_cnt, m_pvl, m_pvr, m_ol, m_or;
    bit m_pl, m_pr, m_band, m_ov;

    function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction
    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction
    function automatic int det_lv(int c);
        int t[4] = '{24573, 20439, 16423, 12316};
        return t[c];
    endfunction
    function automatic int band_lv(int c);
        int t[4] = '{20439, 16423, 12316, 8231};
        return t[c];
    endfunction
    function automatic int steps(int mode, int zn);
        int t[4][4] = '{'{1,1,1,1}, '{2,2,2,2}, '{2,4,4,8}, '{1,2,4,8}};
        return t[mode][zn];
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_att = 0; m_al = 0; m_ar = 0; m_cnt = 0; m_pvl = 0; m_pvr = 0;
            m_ol = 0; m_or = 0; m_pl = 0; m_pr = 0; m_band = 0; m_ov = 0;
        end else begin
            m_ov = in_valid;
            if (in_valid) begin
                int l, r, pk, zn, st, na;
                bit imm, trig, zl, zr, to;
                l  = int'($signed(in_left));
                r  = int'($signed(in_right));
                pk = (iabs(l) > iabs(r)) ? iabs(l) : iabs(r);
                zn = (pk >= 130452) ? 3 : (pk >= 65381) ? 2 : (pk >= 32768) ? 1 : 0;
                st = zc_gate_en ? steps(int'(step_sel), zn) : 1;
                imm  = !zc_gate_en || (fast_en && pk >= 32768);
                trig = lim_en && pk >= det_lv(int'(det_sel)) && (imm || !(m_pl || m_pr));
                zl = (l == 0) || ((l < 0) != (m_pvl < 0));
                zr = (r == 0) || ((r < 0) != (m_pvr < 0));
                if (trig) begin
                    na = (m_att + st > 255) ? 255 : m_att + st;
                    m_att = na; m_cnt = 0;
                    if (imm) begin m_al = na; m_ar = na; m_pl = 0; m_pr = 0; end
                    else begin m_pl = 1; m_pr = 1; end
                end else if (m_pl || m_pr) begin
                    m_cnt = m_cnt + 1;
                    to = m_cnt >= (128 << tmo_sel);
                    if (m_pl && (zl || to)) begin m_al = m_att; m_pl = 0; end
                    if (m_pr && (zr || to)) begin m_ar = m_att; m_pr = 0; end
                end
                m_pvl = l; m_pvr = r;
                m_band = pk < det_lv(int'(det_sel)) && pk >= band_lv(int'(det_sel));
                m_ol = sat16(l); m_or = sat16(r);
            end
        end
    end

    task automatic chk(int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s during %s: actual=%0d expected=%0d", what, phase, act, exp);
        end
    endtask

    always @(negedge clk) if (started) begin
        chk(int'(out_valid), int'(m_ov), "R11 out_valid");
        chk(int'($signed(out_left)), m_ol, "R11 out_left");
        chk(int'($signed(out_right)), m_or, "R11 out_right");
        chk(int'(att_shared), m_att, "R1 att_shared");
        chk(int'(att_left), m_al, "R6 att_left");
        chk(int'(att_right), m_ar, "R6 att_right");
        chk(int'(rcv_band), int'(m_band), "R10 rcv_band");
    end

    task automatic smp(int l, int r);
        @(negedge clk);
        in_valid = 1'b1; in_left = 19'(l); in_right = 19'(r);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(bit en, int det, int stp, int tmo, bit zc, bit fst);
        @(negedge clk);
        lim_en = en; det_sel = 2'(det); step_sel = 2'(stp);
        tmo_sel = 2'(tmo); zc_gate_en = zc; fast_en = fst;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog during %s: actual=hung expected=done", phase);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);               // R13 reset state compared each cycle

        phase = "R4 no zero-cross gating";
        cfg(1, 0, 3, 0, 0, 0);
        repeat (5) smp(30000, -100);
        smp(140000, 0); smp(-200000, 5);

        phase = "R2 detection boundaries";
        for (int c = 0; c < 4; c++) begin
            cfg(1, c, 0, 0, 0, 0);
            smp(det_lv(c) - 1, 0); smp(0, -(det_lv(c) - 1));
            smp(det_lv(c), 0); smp(0, -det_lv(c));
        end

        phase = "R3 R5 step zones fast mode";
        do_reset();
        cfg(1, 0, 2, 0, 1, 1);
        smp(40000, 0); smp(0, 70000); smp(131000, 0); smp(-130452, 10);
        cfg(1, 0, 3, 0, 1, 1);
        smp(40000, 1); smp(-66000, 2); smp(32768, -3);
        cfg(1, 0, 1, 0, 1, 1);
        smp(33000, 4);
        cfg(1, 0, 0, 0, 1, 1);
        smp(135000, 5);

        phase = "R6 R8 zero-cross pickup";
        do_reset();
        cfg(1, 0, 0, 3, 1, 0);
        smp(25000, 25000); smp(26000, 26000); smp(-5, 27000);
        smp(10, 28000); smp(5, -3); smp(50000, 50000); smp(60000, 60000);
        smp(0, 1); smp(3, 0);
        cfg(1, 0, 2, 3, 1, 1);
        smp(25000, 25000); smp(40000, 40000);  // R5 overrides pending

        phase = "R7 timeout 128";
        do_reset();
        cfg(1, 0, 0, 0, 1, 0);
        repeat (132) smp(30000, 30000);
        phase = "R7 timeout 1024";
        cfg(1, 0, 0, 3, 1, 0);
        repeat (1030) smp(30000, 30000);
        phase = "R7 timeout 256 512";
        cfg(1, 0, 0, 1, 1, 0);
        repeat (260) smp(30000, 30000);
        cfg(1, 0, 0, 2, 1, 0);
        repeat (515) smp(30000, 30000);

        phase = "R9 disable";
        do_reset();
        cfg(1, 0, 0, 2, 1, 0);
        smp(30000, 30000);
        cfg(0, 0, 0, 2, 0, 0);
        repeat (4) smp(100000, -100000);
        smp(-1, -1);

        phase = "R12 saturation";
        do_reset();
        cfg(1, 0, 0, 0, 0, 0);
        repeat (262) smp(40000, 40000);
        cfg(1, 0, 2, 0, 1, 1);
        smp(200000, 200000);

        phase = "R10 recovery band";
        do_reset();
        for (int c = 0; c < 4; c++) begin
            cfg(0, c, 0, 0, 1, 0);
            smp(band_lv(c), 0); smp(band_lv(c) - 1, 0);
            smp(0, -(det_lv(c) - 1)); smp(det_lv(c), 0);
        end

        phase = "R11 clipping";
        smp(40000, -40000); smp(-262144, 262143); smp(1234, -1234);
        smp(32767, -32768); smp(32768, -32769);

        phase = "R1 random";
        do_reset();
        for (int k = 0; k < 60; k++) begin
            cfg(($urandom_range(0, 9) != 0), $urandom_range(0, 3), $urandom_range(0, 3),
                0, ($urandom_range(0, 3) != 0), $urandom_range(0, 1));
            for (int j = 0; j < 40; j++) begin
                int a, b;
                a = $urandom_range(0, 4) == 0 ? $urandom_range(0, 140000) : $urandom_range(0, 26000);
                b = $urandom_range(0, 4) == 0 ? $urandom_range(0, 140000) : $urandom_range(0, 26000);
                if ($urandom_range(0, 1) != 0) a = -a;
                if ($urandom_range(0, 1) != 0) b = -b;
                if ($urandom_range(0, 2) == 0) @(negedge clk);
                smp(a, b);
            end
        end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule